// File: doc/BRIEF.md
# Multicycle 16-bit Register-File Processor Core

This core runs programs held in an external word-addressed memory. It has no pipeline. Each instruction passes through a small state sequence: a fetch, a one-cycle decode with the bus idle, and, when needed, either a second-word fetch, a data read or a data write. The datapath holds eight 16-bit general registers, a program counter and a latched copy of the opcode and register fields. A single-cycle ALU/shift unit computes every register-to-register result.

Memory accesses use one 16-bit address, separate 16-bit read and write data paths, a valid strobe, a write strobe and a ready input. A read holds its request until ready is seen high, and the data is captured on that same cycle. A write occupies the bus for exactly one cycle and does not wait for ready. Opcodes outside the supported set do nothing except consume their word.

Top module: `mc16_core`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, the core requests a read (valid 1, write 0) at address 0x0000.
- R2: A read holds valid 1, write 0 and a stable address until ready is sampled high. The data is captured on that ready cycle.
- R3: STORE (opcode 00010) issues exactly one bus cycle with valid 1 and write 1. The address comes from the register named by bits 2:0 and the data from the register named by bits 5:3.
- R4: Bits 15:11 hold the opcode, bits 5:3 the source register and bits 2:0 the destination register. MOVE (00011) copies the source into the destination and leaves the source unchanged.
- R5: LOADI (00100) writes the following word into the destination register, and execution continues after that word.
- R6: LOAD (00001) writes the memory word addressed by the source register into the destination register. Together with STORE this is enough for a loop that copies memory blocks.
- R7: Each operation below writes its result to the destination register, modulo 2^16:
  - INC (00111): destination plus 1.
  - ADD (01101): destination plus source.
  - SUB (01110): destination minus source.
  - AND (01001), OR (01010), XOR (01011): the bitwise result of destination and source.
  - NOT (01100): the inverted source.
  - ZERO (01111): 0.
- R8: Each shift writes the source moved by one bit into the destination:
  - SHL (11010): left, with 0 entering.
  - SHR (11011): right, with 0 entering.
  - ROTL (11101): left rotation.
  - ROTR (11100): right rotation.
- R9: BRANCHI (00101) loads the program counter with the following word.
- R10: BRANCHGTI (00110) jumps to the following word if the register in bits 5:3 is greater than the register in bits 2:0, compared unsigned. Otherwise it continues after that word.
- R11: Every other opcode leaves all registers unchanged, including 00000, 01000, 10000 to 11001, 11110 and 11111.
- R12: After each instruction word is captured, the bus is idle (valid 0) for one decode cycle before the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_i | input | 1 | Memory read data is valid |
| rdata_i | input | 16 | Read data from memory |
| addr_o | output | 16 | Memory address |
| wdata_o | output | 16 | Write data to memory |
| rw_o | output | 1 | 1 = write, 0 = read |
| vma_o | output | 1 | Address and strobe are valid |

## Verification
Register contents are not visible at the ports, so a corrupted register or a wrong ALU result shows up only when a later STORE writes it out. For the test programs, that store follows within a few instructions, and the wrong word appears in memory about ten cycles after the faulty operation. A broken sequencer is visible at once on the bus. A missing decode gap, a write strobe held too long or an address that moves before ready all appear as illegal strobe patterns within one or two cycles. A wrong branch decision changes which marker word gets stored. A miscounted program counter during the block copy shifts or truncates the whole destination image.

// File: rtl/mc16_pkg.sv
`timescale 1ns/1ps
package mc16_pkg;
  localparam int OPW = 5;

  localparam logic [OPW-1:0] OP_NOP   = 5'b00000;
  localparam logic [OPW-1:0] OP_LOAD  = 5'b00001;
  localparam logic [OPW-1:0] OP_STORE = 5'b00010;
  localparam logic [OPW-1:0] OP_MOVE  = 5'b00011;
  localparam logic [OPW-1:0] OP_LOADI = 5'b00100;
  localparam logic [OPW-1:0] OP_BRI   = 5'b00101;
  localparam logic [OPW-1:0] OP_BRGTI = 5'b00110;
  localparam logic [OPW-1:0] OP_INC   = 5'b00111;
  localparam logic [OPW-1:0] OP_AND   = 5'b01001;
  localparam logic [OPW-1:0] OP_OR    = 5'b01010;
  localparam logic [OPW-1:0] OP_XOR   = 5'b01011;
  localparam logic [OPW-1:0] OP_NOT   = 5'b01100;
  localparam logic [OPW-1:0] OP_ADD   = 5'b01101;
  localparam logic [OPW-1:0] OP_SUB   = 5'b01110;
  localparam logic [OPW-1:0] OP_ZERO  = 5'b01111;
  localparam logic [OPW-1:0] OP_SHL   = 5'b11010;
  localparam logic [OPW-1:0] OP_SHR   = 5'b11011;
  localparam logic [OPW-1:0] OP_ROTR  = 5'b11100;
  localparam logic [OPW-1:0] OP_ROTL  = 5'b11101;

  typedef enum logic [3:0] {
    ALU_PASS, ALU_INC, ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR,
    ALU_NOT, ALU_ZERO, ALU_SHL, ALU_SHR, ALU_ROTL, ALU_ROTR
  } alu_op_e;

  typedef enum logic [2:0] {S_FETCH, S_DEC, S_IMM, S_RD, S_WR} state_e;
endpackage

// File: rtl/mc16_regfile.sv
`timescale 1ns/1ps
module mc16_regfile #(
  parameter int DW  = 16,
  parameter int RAW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [RAW-1:0] waddr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [RAW-1:0] raddr_a_i,
  output logic [DW-1:0]  rdata_a_o,
  input  logic [RAW-1:0] raddr_b_i,
  output logic [DW-1:0]  rdata_b_o
);
  localparam int NREG = 1 << RAW;

  logic [DW-1:0] rf_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) rf_q[i] <= '0;
    end else if (we_i) begin
      rf_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = rf_q[raddr_a_i];
  assign rdata_b_o = rf_q[raddr_b_i];

  // R6: a write lands in the addressed register
  p_write_lands_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rf_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/mc16_alu.sv
`timescale 1ns/1ps
module mc16_alu
  import mc16_pkg::*;
#(
  parameter int DW = 16
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,   // source register
  input  logic [DW-1:0] b_i,   // destination register
  output logic [DW-1:0] y_o
);
  always_comb begin
    case (op_i)
      ALU_PASS: y_o = a_i;
      ALU_INC:  y_o = b_i + 1'b1;
      ALU_ADD:  y_o = b_i + a_i;
      ALU_SUB:  y_o = b_i - a_i;
      ALU_AND:  y_o = b_i & a_i;
      ALU_OR:   y_o = b_i | a_i;
      ALU_XOR:  y_o = b_i ^ a_i;
      ALU_NOT:  y_o = ~a_i;
      ALU_SHL:  y_o = {a_i[DW-2:0], 1'b0};
      ALU_SHR:  y_o = {1'b0, a_i[DW-1:1]};
      ALU_ROTL: y_o = {a_i[DW-2:0], a_i[DW-1]};
      ALU_ROTR: y_o = {a_i[0], a_i[DW-1:1]};
      default:  y_o = '0;
    endcase
  end

  always_comb begin
    if (op_i == ALU_SUB) begin
      p_sub_inverse_r7: assert (y_o + a_i == b_i);
    end
    if (op_i == ALU_ROTL) begin
      p_rotl_bits_r8: assert ($countones(y_o) == $countones(a_i));
    end
  end
endmodule

// File: rtl/mc16_core.sv
`timescale 1ns/1ps
module mc16_core
  import mc16_pkg::*;
#(
  parameter int DW  = 16,
  parameter int AW  = 16,
  parameter int RAW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ready_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          rw_o,
  output logic          vma_o
);
  state_e         state_q;
  logic [AW-1:0]  pc_q;
  logic [OPW-1:0] op_q;
  logic [RAW-1:0] src_q, dst_q;

  logic [DW-1:0]  src_val, dst_val, alu_y, rf_wdata;
  alu_op_e        alu_op;
  logic           alu_we, dbl, take_br, rf_we;

  mc16_regfile #(.DW(DW), .RAW(RAW)) u_rf (
    .clk_i, .rst_ni,
    .we_i(rf_we), .waddr_i(dst_q), .wdata_i(rf_wdata),
    .raddr_a_i(src_q), .rdata_a_o(src_val),
    .raddr_b_i(dst_q), .rdata_b_o(dst_val)
  );

  mc16_alu #(.DW(DW)) u_alu (
    .op_i(alu_op), .a_i(src_val), .b_i(dst_val), .y_o(alu_y)
  );

  always_comb begin
    alu_we = 1'b1;
    alu_op = ALU_PASS;
    case (op_q)
      OP_MOVE: alu_op = ALU_PASS;
      OP_INC:  alu_op = ALU_INC;
      OP_ADD:  alu_op = ALU_ADD;
      OP_SUB:  alu_op = ALU_SUB;
      OP_AND:  alu_op = ALU_AND;
      OP_OR:   alu_op = ALU_OR;
      OP_XOR:  alu_op = ALU_XOR;
      OP_NOT:  alu_op = ALU_NOT;
      OP_ZERO: alu_op = ALU_ZERO;
      OP_SHL:  alu_op = ALU_SHL;
      OP_SHR:  alu_op = ALU_SHR;
      OP_ROTL: alu_op = ALU_ROTL;
      OP_ROTR: alu_op = ALU_ROTR;
      default: alu_we = 1'b0;  // unsupported codes retire as no-ops
    endcase
  end

  assign dbl     = (op_q == OP_LOADI) || (op_q == OP_BRI) || (op_q == OP_BRGTI);
  assign take_br = (op_q == OP_BRI) || ((op_q == OP_BRGTI) && (src_val > dst_val));

  assign rf_we    = ((state_q == S_DEC) && alu_we)
                 || (ready_i && (((state_q == S_IMM) && (op_q == OP_LOADI)) || (state_q == S_RD)));
  assign rf_wdata = (state_q == S_DEC) ? alu_y : rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_FETCH;
      pc_q    <= '0;
      op_q    <= OP_NOP;
      src_q   <= '0;
      dst_q   <= '0;
    end else begin
      case (state_q)
        S_FETCH: if (ready_i) begin
          op_q    <= rdata_i[DW-1 -: OPW];
          src_q   <= rdata_i[2*RAW-1 -: RAW];
          dst_q   <= rdata_i[RAW-1:0];
          pc_q    <= pc_q + 1'b1;
          state_q <= S_DEC;
        end
        S_DEC: begin
          if (dbl)                  state_q <= S_IMM;
          else if (op_q == OP_LOAD)  state_q <= S_RD;
          else if (op_q == OP_STORE) state_q <= S_WR;
          else                      state_q <= S_FETCH;
        end
        S_IMM: if (ready_i) begin
          pc_q    <= take_br ? AW'(rdata_i) : pc_q + 1'b1;
          state_q <= S_FETCH;
        end
        S_RD: if (ready_i) state_q <= S_FETCH;
        default: state_q <= S_FETCH;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      S_RD:    addr_o = AW'(src_val);
      S_WR:    addr_o = AW'(dst_val);
      default: addr_o = pc_q;
    endcase
  end

  assign vma_o   = (state_q != S_DEC);
  assign rw_o    = (state_q == S_WR);
  assign wdata_o = src_val;

  p_start_at_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (addr_o == '0 && vma_o && !rw_o));

  p_read_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vma_o && !rw_o && !ready_i) |=> (vma_o && !rw_o && $stable(addr_o)));

  p_write_once_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rw_o |=> !rw_o);

  p_imm_skip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IMM && ready_i && op_q == OP_LOADI) |=> pc_q == $past(pc_q) + 1'b1);

  p_branch_target_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IMM && ready_i && op_q == OP_BRI) |=> pc_q == AW'($past(rdata_i)));

  p_idle_after_fetch_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_FETCH && ready_i) |=> !vma_o);
endmodule

// File: tb/mc16_core_tb.sv
`timescale 1ns/1ps
module mc16_core_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ready_i;
  logic [15:0] rdata_i;
  logic [15:0] addr_o, wdata_o;
  logic        rw_o, vma_o;

  logic [15:0] mem [256];
  int          wr_count;
  int          n_checks = 0;
  int          n_err = 0;

  always #5 clk_i = ~clk_i;  // 100 MHz

  mc16_core u_dut (
    .clk_i, .rst_ni, .ready_i, .rdata_i, .addr_o, .wdata_o, .rw_o, .vma_o
  );

  // memory model: ready one cycle after a valid read, writes take one cycle
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      ready_i  <= 1'b0;
      wr_count <= 0;
    end else begin
      ready_i <= vma_o && !rw_o && !ready_i;
      if (vma_o && rw_o) begin
        mem[addr_o[7:0]] <= wdata_o;
        wr_count <= wr_count + 1;
      end
    end
    rdata_i <= mem[addr_o[7:0]];
  end

  localparam logic [4:0] C_LOAD  = 5'b00001, C_STORE = 5'b00010, C_LOADI = 5'b00100,
                         C_BRI   = 5'b00101, C_BRGTI = 5'b00110, C_INC   = 5'b00111;

  function automatic logic [15:0] enc(logic [4:0] op, logic [2:0] s, logic [2:0] d);
    return {op, 5'b0, s, d};
  endfunction

  function automatic logic [31:0] pair(int k);
    case (k)
      0: return {16'h0000, 16'h0000};
      1: return {16'h1234, 16'h00FF};
      2: return {16'h8001, 16'h7FFF};
      3: return {16'hFFFF, 16'h0001};
      4: return {16'h00F0, 16'h0F0F};
      default: return {16'hAAAA, 16'h5555};
    endcase
  endfunction

  // expected destination value: a = source, b = destination
  function automatic logic [15:0] model(logic [4:0] op, logic [15:0] a, logic [15:0] b);
    case (op)
      5'b00011: return a;
      5'b00111: return b + 16'd1;
      5'b01001: return a & b;
      5'b01010: return a | b;
      5'b01011: return a ^ b;
      5'b01100: return ~a;
      5'b01101: return b + a;
      5'b01110: return b - a;
      5'b01111: return 16'h0000;
      5'b11010: return {a[14:0], 1'b0};
      5'b11011: return {1'b0, a[15:1]};
      5'b11100: return {a[0], a[15:1]};
      5'b11101: return {a[14:0], a[15]};
      default:  return b;
    endcase
  endfunction

  function automatic string req_of(logic [4:0] op);
    case (op)
      5'b00011: return "R4";
      5'b11010, 5'b11011, 5'b11100, 5'b11101: return "R8";
      5'b00111, 5'b01001, 5'b01010, 5'b01011, 5'b01100, 5'b01101, 5'b01110, 5'b01111: return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hold_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] <= 16'h0000;
  endtask

  task automatic release_reset();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #1000000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    // block copy 0x10..0x2F -> 0x30..0x4F, also reset/bus checks
    hold_reset();
    mem[0]  <= enc(C_LOADI, 0, 1); mem[1]  <= 16'h0010;
    mem[2]  <= enc(C_LOADI, 0, 2); mem[3]  <= 16'h0030;
    mem[4]  <= enc(C_LOADI, 0, 6); mem[5]  <= 16'h002F;
    mem[6]  <= enc(C_LOAD, 1, 3);
    mem[7]  <= enc(C_STORE, 3, 2);
    mem[8]  <= enc(C_INC, 0, 1);
    mem[9]  <= enc(C_INC, 0, 2);
    mem[10] <= enc(C_BRGTI, 1, 6); mem[11] <= 16'h000E;
    mem[12] <= enc(C_BRI, 0, 0);   mem[13] <= 16'h0006;
    mem[14] <= enc(C_BRI, 0, 0);   mem[15] <= 16'h000E;
    for (int i = 0; i < 32; i++) mem[16 + i] <= 16'(i * 263) ^ 16'hA500;
    @(negedge clk_i);
    check("R1 reset addr", addr_o, 16'h0000);
    check("R1 reset strobes", {14'd0, vma_o, rw_o}, 16'h0002);
    release_reset();
    @(negedge clk_i);
    check("R1 first cycle", {addr_o[13:0], vma_o, rw_o}, 16'h0002);
    @(negedge clk_i);
    check("R12 decode idle", {15'd0, vma_o}, 16'h0000);
    wait_cycles(1000);
    for (int i = 0; i < 32; i++)
      check("R6 block copy", mem[48 + i], 16'(i * 263) ^ 16'hA500);
    check("R6 copy bound", mem[80], 16'h0000);
    check("R10 copy source intact", mem[47], 16'(31 * 263) ^ 16'hA500);

    // near-exhaustive single-word opcode sweep
    for (int op = 0; op < 32; op++) begin
      if (op == 1 || op == 2 || op == 4 || op == 5 || op == 6) continue;
      for (int k = 0; k < 6; k++) begin
        logic [31:0] ab;
        ab = pair(k);
        hold_reset();
        mem[0]  <= enc(C_LOADI, 0, 1); mem[1] <= ab[31:16];
        mem[2]  <= enc(C_LOADI, 0, 2); mem[3] <= ab[15:0];
        mem[4]  <= enc(5'(op), 1, 2);
        mem[5]  <= enc(C_LOADI, 0, 3); mem[6] <= 16'h0040;
        mem[7]  <= enc(C_STORE, 2, 3);
        mem[8]  <= enc(C_INC, 0, 3);
        mem[9]  <= enc(C_STORE, 1, 3);
        mem[10] <= enc(C_BRI, 0, 0);   mem[11] <= 16'h000A;
        release_reset();
        wait_cycles(50);
        check(req_of(5'(op)), mem[8'h40], model(5'(op), ab[31:16], ab[15:0]));
        check("R4 source kept", mem[8'h41], ab[31:16]);
        check("R3 one write per store", 16'(wr_count), 16'd2);
      end
    end

    // conditional branch, both operand orders
    for (int k = 0; k < 12; k++) begin
      logic [31:0] ab;
      logic [15:0] a, b;
      ab = pair(k % 6);
      a = (k < 6) ? ab[31:16] : ab[15:0];
      b = (k < 6) ? ab[15:0] : ab[31:16];
      hold_reset();
      mem[0]  <= enc(C_LOADI, 0, 1); mem[1]  <= a;
      mem[2]  <= enc(C_LOADI, 0, 2); mem[3]  <= b;
      mem[4]  <= enc(C_BRGTI, 1, 2); mem[5]  <= 16'h000A;
      mem[6]  <= enc(C_LOADI, 0, 4); mem[7]  <= 16'h0001;
      mem[8]  <= enc(C_BRI, 0, 0);   mem[9]  <= 16'h000C;
      mem[10] <= enc(C_LOADI, 0, 4); mem[11] <= 16'h0002;
      mem[12] <= enc(C_LOADI, 0, 3); mem[13] <= 16'h0040;
      mem[14] <= enc(C_STORE, 4, 3);
      mem[15] <= enc(C_BRI, 0, 0);   mem[16] <= 16'h000F;
      release_reset();
      wait_cycles(60);
      check("R10 branch decision", mem[8'h40], (a > b) ? 16'h0002 : 16'h0001);
      check("R9 branch lands", 16'(wr_count), 16'd1);
      check("R5 loadi words", mem[8'h41], 16'h0000);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule